// File: doc/BRIEF.md
# Hysteresis Threshold Gate

This block is a state-holding threshold element for a clock-less dual-rail logic style. It has N input wires and one output. The output rises once at least M of the N inputs are asserted. After that it stays high until every input has returned low. While neither of those two conditions holds, the output keeps its previous value. This hysteresis lets a set of these gates make up dual-rail arithmetic and the trees that detect when a wavefront is complete. A whole wavefront of data must arrive before an output rises, and a whole wavefront of spacers must arrive before it falls.

In this synthesizable model the internal feedback loop is a register. The register samples the next-state equation on a free-running clock, so each output change appears one rising edge after the input vector that causes it. The top module also carries a separate fixed 2-of-3 gate. That gate is written out as a sum of products, AB + BC + AC + (A + B + C)·Z, and sits beside the parameterized gate.

Top module: `hyst_thresh_gate`

## Requirements
- R1: When `rst` is high at a rising edge, both `z_out` and `tri_z` are 0 after that edge, whatever the inputs are.
- R2: If `z_out` is 0 and at least M bits of `in_vec` are 1 at a rising edge, `z_out` is 1 after that edge.
- R3: If `z_out` is 1 and at least one bit of `in_vec` is 1 at a rising edge, `z_out` stays 1 after that edge, even when fewer than M bits are 1.
- R4: If every bit of `in_vec` is 0 at a rising edge, `z_out` is 0 after that edge.
- R5: If `z_out` is 0 and fewer than M bits of `in_vec` are 1 at a rising edge, `z_out` stays 0 after that edge.
- R6: `tri_z` follows the 2-of-3 rule on `tri_in`. With bits A, B, C, the value after each edge is AB + BC + AC + ((A + B + C) AND the previous `tri_z`).
- R7: The behaviour in R2 to R5 holds for every legal threshold 1 ≤ M ≤ N. In particular, M = 1 gives a registered OR of the inputs, and M = N needs all inputs high to set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock that stands in for the feedback loop |
| rst | input | 1 | Synchronous active-high reset that clears both held outputs |
| in_vec | input | N | Input wires of the parameterized gate |
| z_out | output | 1 | Held output of the M-of-N gate |
| tri_in | input | 3 | Inputs A (bit 0), B (bit 1) and C (bit 2) of the fixed 2-of-3 gate |
| tri_z | output | 1 | Held output of the fixed 2-of-3 gate |

## Verification
Both outputs are due exactly one rising edge after the input vector that decides them. No combinational path runs from any input to any output. The bench applies each new vector just after a falling edge and compares the outputs at the next falling edge, which is half a period after the edge that registers them. A reference model in the bench updates its own held bit once per vector, so each comparison always pairs one applied vector with the state that vector produces. The sweeps reset the gates before every input sequence, so each sequence starts from the cleared state.

// File: rtl/th_gate_pkg.sv
`timescale 1ns/1ps
package th_gate_pkg;

    // Register contents of a hysteresis gate: the single held output bit.
    typedef struct packed {
        logic held;
    } th_state_t;

    // Width needed to count from 0 to n inclusive.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/th_popcount.sv
`timescale 1ns/1ps
module th_popcount #(
    parameter int unsigned N = 4,
    localparam int unsigned CW = th_gate_pkg::cnt_width(N)
) (
    input  logic [N-1:0]  bits,
    output logic [CW-1:0] count
);

    // Ripple accumulation; each stage adds one input bit.
    logic [CW-1:0] part [N+1];

    assign part[0] = '0;

    for (genvar i = 0; i < N; i++) begin : g_add
        assign part[i+1] = part[i] + CW'(bits[i]);
    end

    assign count = part[N];

endmodule

// File: rtl/th_hyst_core.sv
`timescale 1ns/1ps
module th_hyst_core
    import th_gate_pkg::*;
#(
    parameter int unsigned N = 4,
    parameter int unsigned M = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] in_vec,
    output logic         z_out
);

    localparam int unsigned CW = cnt_width(N);
    localparam logic [CW-1:0] THRESH = CW'(M);

    logic [CW-1:0] ones_cnt;
    logic          set_hit;
    logic          any_high;
    th_state_t     st_d, st_q;

    th_popcount #(.N(N)) u_cnt (
        .bits  (in_vec),
        .count (ones_cnt)
    );

    always_comb begin
        set_hit     = (ones_cnt >= THRESH);
        any_high    = |in_vec;
        st_d        = st_q;
        st_d.held   = set_hit | (any_high & st_q.held);
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign z_out = st_q.held;

endmodule

// File: rtl/th_fixed23.sv
`timescale 1ns/1ps
module th_fixed23
    import th_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] abc,
    output logic       z
);

    logic      a_w, b_w, c_w;
    th_state_t st_d, st_q;

    assign a_w = abc[0];
    assign b_w = abc[1];
    assign c_w = abc[2];

    // Sum of products for the set term, plus the OR of all inputs gating feedback.
    always_comb begin
        st_d      = st_q;
        st_d.held = (a_w & b_w) | (b_w & c_w) | (a_w & c_w)
                  | ((a_w | b_w | c_w) & st_q.held);
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign z = st_q.held;

endmodule

// File: rtl/hyst_thresh_gate.sv
`timescale 1ns/1ps
module hyst_thresh_gate #(
    parameter int unsigned N = 4,
    parameter int unsigned M = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] in_vec,
    output logic         z_out,
    input  logic [2:0]   tri_in,
    output logic         tri_z
);

    if ((M < 1) || (M > N)) begin : g_bad_threshold
        $error("hyst_thresh_gate: threshold must satisfy 1 <= M <= N");
    end

    th_hyst_core #(.N(N), .M(M)) u_core (
        .clk    (clk),
        .rst    (rst),
        .in_vec (in_vec),
        .z_out  (z_out)
    );

    th_fixed23 u_tri (
        .clk (clk),
        .rst (rst),
        .abc (tri_in),
        .z   (tri_z)
    );

endmodule

// File: rtl/th_gate_chk.sv
`timescale 1ns/1ps
module th_gate_chk #(
    parameter int unsigned N = 4,
    parameter int unsigned M = 3
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] in_vec,
    input logic         z_out,
    input logic [2:0]   tri_in,
    input logic         tri_z
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!z_out && !tri_z));

    assert_set_on_threshold_R2: assert property (@(posedge clk) disable iff (rst)
        ($countones(in_vec) >= M) |=> z_out);

    assert_hold_while_any_R3: assert property (@(posedge clk) disable iff (rst)
        (z_out && (in_vec != '0)) |=> z_out);

    assert_release_all_low_R4: assert property (@(posedge clk) disable iff (rst)
        (in_vec == '0) |=> !z_out);

    assert_no_early_set_R5: assert property (@(posedge clk) disable iff (rst)
        (!z_out && ($countones(in_vec) < M)) |=> !z_out);

    assert_tri_set_R6: assert property (@(posedge clk) disable iff (rst)
        ($countones(tri_in) >= 2) |=> tri_z);

    assert_tri_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (tri_z && (tri_in != 3'b000)) |=> tri_z);

    assert_tri_release_R6: assert property (@(posedge clk) disable iff (rst)
        ((tri_in == 3'b000) || (!tri_z && ($countones(tri_in) < 2))) |=> !tri_z);

endmodule

bind hyst_thresh_gate th_gate_chk #(.N(N), .M(M)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .in_vec (in_vec),
    .z_out  (z_out),
    .tri_in (tri_in),
    .tri_z  (tri_z)
);

// File: tb/sim_hyst_thresh_gate.sv
`timescale 1ns/1ps
module sim_hyst_thresh_gate;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] s4  = '0;
    logic [2:0] s3  = '0;
    logic [2:0] tri_s = '0;
    logic       z0, tz0;
    logic [3:1] z3;
    logic [4:1] z4;
    logic [3:1] tz3_unused;
    logic [4:1] tz4_unused;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    // Default instance: N=4, M=3, plus the fixed 2-of-3 gate.
    hyst_thresh_gate u0 (
        .clk(clk), .rst(rst), .in_vec(s4), .z_out(z0),
        .tri_in(tri_s), .tri_z(tz0)
    );

    for (genvar k = 1; k <= 3; k++) begin : g_n3
        hyst_thresh_gate #(.N(3), .M(k)) u_g (
            .clk(clk), .rst(rst), .in_vec(s3), .z_out(z3[k]),
            .tri_in(3'b000), .tri_z(tz3_unused[k])
        );
    end

    for (genvar k = 1; k <= 4; k++) begin : g_n4
        hyst_thresh_gate #(.N(4), .M(k)) u_g (
            .clk(clk), .rst(rst), .in_vec(s4), .z_out(z4[k]),
            .tri_in(3'b000), .tri_z(tz4_unused[k])
        );
    end

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int ones(input logic [3:0] v);
        int c = 0;
        for (int i = 0; i < 4; i++) c += int'(v[i]);
        return c;
    endfunction

    // Which rule decides the next state, for failure messages.
    function automatic string rule_of(input logic prev, input int cnt, input int thr, input bit zero);
        if (zero) return "R4";
        if (prev) return "R3";
        if (cnt >= thr) return "R2";
        return "R5";
    endfunction

    // Entry: {rst, tri[2:0], vec[3:0], exp_tri, exp_z}
    localparam int NT = 16;
    localparam logic [9:0] TBL [NT] = '{
        {1'b1, 3'b000, 4'b0000, 1'b0, 1'b0},
        {1'b0, 3'b001, 4'b0001, 1'b0, 1'b0},
        {1'b0, 3'b011, 4'b0011, 1'b1, 1'b0},
        {1'b0, 3'b010, 4'b0111, 1'b1, 1'b1},
        {1'b0, 3'b000, 4'b0001, 1'b0, 1'b1},
        {1'b0, 3'b100, 4'b1000, 1'b0, 1'b1},
        {1'b0, 3'b110, 4'b0000, 1'b1, 1'b0},
        {1'b0, 3'b111, 4'b1011, 1'b1, 1'b1},
        {1'b0, 3'b100, 4'b1011, 1'b1, 1'b1},
        {1'b0, 3'b000, 4'b0000, 1'b0, 1'b0},
        {1'b0, 3'b101, 4'b1101, 1'b1, 1'b1},
        {1'b1, 3'b111, 4'b1111, 1'b0, 1'b0},
        {1'b0, 3'b001, 4'b0110, 1'b0, 1'b0},
        {1'b0, 3'b011, 4'b1111, 1'b1, 1'b1},
        {1'b0, 3'b001, 4'b1000, 1'b1, 1'b1},
        {1'b0, 3'b000, 4'b0100, 1'b0, 1'b1}
    };

    initial begin : watchdog
        #(4 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic m3 [1:3];
        logic m4 [1:4];
        string tg3 [1:3];
        string tg4 [1:4];

        // Reset state: R1
        rst = 1'b1; s4 = 4'b1111; s3 = 3'b111; tri_s = 3'b111;
        @(negedge clk);
        @(negedge clk);
        chk("R1 z_out under reset", z0, 1'b0);
        chk("R1 tri_z under reset", tz0, 1'b0);

        // Table walk: R6 for the fixed gate, R2..R5 for u0
        for (int t = 0; t < NT; t++) begin
            rst   = TBL[t][9];
            tri_s = TBL[t][8:6];
            s4    = TBL[t][5:2];
            @(negedge clk);
            chk($sformatf("R6 table row %0d tri_z", t), tz0, TBL[t][1]);
            chk($sformatf("R2/R3/R4/R5 table row %0d z_out", t), z0, TBL[t][0]);
        end

        // Directed: reset dominates a full set vector (R1)
        rst = 1'b0; s4 = 4'b1111; tri_s = 3'b111;
        @(negedge clk);
        chk("R2 set before reset test", z0, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset beats set condition", z0, 1'b0);
        chk("R1 reset beats tri set", tz0, 1'b0);

        // Directed: long hold on a single input, then release (R3, R4)
        rst = 1'b0; s4 = 4'b0111;
        @(negedge clk);
        s4 = 4'b0100;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R3 single input keeps output high", z0, 1'b1);
        end
        s4 = 4'b0000;
        @(negedge clk);
        chk("R4 all low clears output", z0, 1'b0);
        s4 = 4'b0110;
        @(negedge clk);
        chk("R5 below threshold from low", z0, 1'b0);

        // Sweep A: N=3, every M, all sequences of 4 vectors (R7)
        for (int q = 0; q < 4096; q++) begin
            rst = 1'b1; s3 = '0;
            @(negedge clk);
            rst = 1'b0;
            for (int k = 1; k <= 3; k++) m3[k] = 1'b0;
            for (int p = 0; p < 4; p++) begin
                s3 = 3'(q >> (3 * p));
                for (int k = 1; k <= 3; k++) begin
                    tg3[k] = rule_of(m3[k], ones({1'b0, s3}), k, (s3 == 3'b000));
                    m3[k]  = (ones({1'b0, s3}) >= k) || ((s3 != 3'b000) && m3[k]);
                end
                @(negedge clk);
                for (int k = 1; k <= 3; k++)
                    chk($sformatf("R7 N=3 M=%0d %s seq=%0d step=%0d", k, tg3[k], q, p), z3[k], m3[k]);
            end
        end

        // Sweep B: N=4, every M, all sequences of 3 vectors (R7)
        for (int q = 0; q < 4096; q++) begin
            rst = 1'b1; s4 = '0;
            @(negedge clk);
            rst = 1'b0;
            for (int k = 1; k <= 4; k++) m4[k] = 1'b0;
            for (int p = 0; p < 3; p++) begin
                s4 = 4'(q >> (4 * p));
                for (int k = 1; k <= 4; k++) begin
                    tg4[k] = rule_of(m4[k], ones(s4), k, (s4 == 4'b0000));
                    m4[k]  = (ones(s4) >= k) || ((s4 != 4'b0000) && m4[k]);
                end
                @(negedge clk);
                for (int k = 1; k <= 4; k++)
                    chk($sformatf("R7 N=4 M=%0d %s seq=%0d step=%0d", k, tg4[k], q, p), z4[k], m4[k]);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule